// File: doc/BRIEF.md
# Directory Coherence Line Controller

This block is the home-side directory engine for a node whose four caches share a small set of tracked lines. For every tracked line it keeps a tag, a coherence state and a four-bit presence vector, one bit per cache. Two message channels come in. One carries requests (virtual network 0). The other carries writebacks, eviction notices, supply responses and invalidate acknowledgements (virtual network 2). A single outgoing channel (virtual network 1) carries data responses, forwarded interventions, invalidates, grants and write-complete notices. Line data itself is not modelled; only the metadata that decides who may hold a line and in what form.

Each channel is a valid/ready handshake that carries an opcode, a line address and a cache id. Request and outgoing messages also carry a transaction id. The low address bits select a tracked line and the remaining bits form its tag. Writes to a shared line are turned into a burst of invalidates. A per-line counter of outstanding acknowledgements then holds the write-complete notice until every acknowledgement has arrived. Any message that has no defined transition in the line's current state is consumed, produces nothing, and latches an error flag.

Top module: `dcl_coh_ctrl`

## Requirements
- R1: After reset every line is Noncached, `rs_valid` and `proto_err` are low, and an idle block raises `rq_ready`.
- R2: A read-exclusive request (req op 1) to a Noncached line returns an exclusive response (out op 1) to the requester and makes it the sole owner. A plain read (req op 0) to a Noncached line returns a shared response (out op 0) and makes the requester the only sharer.
- R3: A plain read to an Exclusive line sends a forwarded read (out op 2) to the owner, carrying the reader's transaction id. The line becomes forward-pending, and request-channel messages for that line are held off (`rq_ready` low) until the line settles.
- R4: A supply-shared message (ev op 0) from the owner of a forward-pending line sends a shared response to the waiting reader with the reader's saved transaction id. The line becomes Shared with both the old owner and the reader present.
- R5: An upgrade (req op 2) from the only present sharer is answered with a grant (out op 3), and the line becomes Exclusive.
- R6: A drop notice (ev op 1) clears the sender's presence bit, and the line returns to Noncached when no bit remains. A writeback (ev op 2) from the owner of an Exclusive line returns it to Noncached.
- R7: A read-exclusive or upgrade to a Shared line that has other sharers sends one invalidate (out op 4) per cycle to each other sharer, in ascending cache id, carrying the requester's transaction id. A write-complete (out op 5) goes to the requester only after as many acknowledgements (ev op 3) as invalidates have arrived.
- R8: While `ev_valid` is high, no request-channel message is accepted. An event message is accepted whenever the output slot is free and no invalidate burst is in progress.
- R9: A message with no defined transition, or whose tag differs from the tag of a non-Noncached line at the same index, is consumed without output and sets `proto_err`, which stays high until reset.
- R10: While `rs_valid` is high and `rs_ready` is low, the outgoing message stays unchanged, and only opcodes 0 to 5 are emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_valid | input | 1 | Request message valid (network 0) |
| rq_ready | output | 1 | Request message accepted |
| rq_op | input | 3 | Request opcode: 0 read, 1 read-exclusive, 2 upgrade |
| rq_addr | input | ADDR_W | Request line address |
| rq_src | input | 2 | Requesting cache id |
| rq_tid | input | TID_W | Request transaction id |
| ev_valid | input | 1 | Event message valid (network 2) |
| ev_ready | output | 1 | Event message accepted |
| ev_op | input | 3 | Event opcode: 0 supply-shared, 1 drop, 2 writeback, 3 invalidate ack |
| ev_addr | input | ADDR_W | Event line address |
| ev_src | input | 2 | Sending cache id |
| rs_valid | output | 1 | Outgoing message valid (network 1) |
| rs_ready | input | 1 | Outgoing message taken |
| rs_op | output | 3 | Outgoing opcode: 0 shared resp, 1 exclusive resp, 2 forward, 3 grant, 4 invalidate, 5 write complete |
| rs_addr | output | ADDR_W | Outgoing line address |
| rs_dst | output | 2 | Destination cache id |
| rs_tid | output | TID_W | Transaction id of the originating request |
| proto_err | output | 1 | Sticky unexpected-message flag |

## Verification
The main function is driven through one line's full life. An exclusive fill is followed by a second reader, which forces an owner intervention, and then a third sharer. That sequence tells the forwarding path apart from the plain shared-add path. An upgrade against two other sharers separates the counted-acknowledgement path from the sole-sharer grant on a second line. A drop, writeback and fresh read-exclusive show whether presence bits were pruned to Noncached or left stale, since stale bits would emit an invalidate. Simultaneous traffic on both inputs, a stalled output and a conflicting tag cover arbitration, hold-while-stalled and the error flag.

// File: rtl/dcl_pkg.sv
// Shared encodings for the directory coherence line controller.
// Assumes 3-bit opcodes on every channel.
package dcl_pkg;
    typedef enum logic [2:0] {
        LN_NONC = 3'd0,
        LN_EXCL = 3'd1,
        LN_SHRD = 3'd2,
        LN_PFWD = 3'd3,
        LN_PINV = 3'd4
    } line_st_e;

    localparam logic [2:0] RQ_RD   = 3'd0;
    localparam logic [2:0] RQ_RDX  = 3'd1;
    localparam logic [2:0] RQ_UPG  = 3'd2;

    localparam logic [2:0] EV_SUP  = 3'd0;
    localparam logic [2:0] EV_DROP = 3'd1;
    localparam logic [2:0] EV_WBK  = 3'd2;
    localparam logic [2:0] EV_IACK = 3'd3;

    localparam logic [2:0] RS_RSH  = 3'd0;
    localparam logic [2:0] RS_REX  = 3'd1;
    localparam logic [2:0] RS_FWD  = 3'd2;
    localparam logic [2:0] RS_GNT  = 3'd3;
    localparam logic [2:0] RS_INV  = 3'd4;
    localparam logic [2:0] RS_WCMP = 3'd5;
endpackage

// File: rtl/dcl_in_arb.sv
// Input arbiter: the event channel (network 2) always wins over requests.
// Assumes can_take already folds in output-slot and invalidate-burst state.
module dcl_in_arb (
    input  logic rq_valid,
    input  logic ev_valid,
    input  logic rq_blocked,
    input  logic can_take,
    output logic rq_ready,
    output logic ev_ready,
    output logic sel_ev,
    output logic fire
);
    // Grant logic: events first, requests only to settled lines.
    always_comb begin
        ev_ready = can_take;
        rq_ready = can_take && !ev_valid && !rq_blocked;
        sel_ev   = ev_valid;
        fire     = (ev_valid && ev_ready) || (rq_valid && rq_ready);
    end
endmodule

// File: rtl/dcl_xition.sv
// Coherence transition function for one line: given the current entry
// and one message, computes the next entry, an optional outgoing message,
// an invalidate burst request and the unexpected-message flag.
// Purely combinational; assumes the caller applies results only on fire.
module dcl_xition
    import dcl_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int SRC_W  = 2,
    parameter int CNT_W  = 3,
    parameter int TAG_W  = 6,
    parameter int TID_W  = 4
) (
    input  logic              is_ev,
    input  logic [2:0]        op,
    input  logic [TAG_W-1:0]  tag,
    input  logic [SRC_W-1:0]  src,
    input  logic [TID_W-1:0]  tid,
    input  line_st_e          cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [NCACHE-1:0] cur_sv,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [SRC_W-1:0]  cur_psrc,
    input  logic [TID_W-1:0]  cur_ptid,
    output line_st_e          nxt_st,
    output logic [TAG_W-1:0]  nxt_tag,
    output logic [NCACHE-1:0] nxt_sv,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic [SRC_W-1:0]  nxt_psrc,
    output logic [TID_W-1:0]  nxt_ptid,
    output logic              emit,
    output logic [2:0]        emit_op,
    output logic [SRC_W-1:0]  emit_dst,
    output logic [TID_W-1:0]  emit_tid,
    output logic              inv_start,
    output logic [NCACHE-1:0] inv_mask,
    output logic              bad
);
    logic [NCACHE-1:0] src_bit, psrc_bit, others;
    logic [SRC_W-1:0]  owner;
    logic [CNT_W-1:0]  others_cnt;
    logic              tag_ok;

    // Derived views of the entry: owner id, other sharers and their count.
    always_comb begin
        src_bit  = NCACHE'(1) << src;
        psrc_bit = NCACHE'(1) << cur_psrc;
        others   = cur_sv & ~src_bit;
        tag_ok   = (cur_st == LN_NONC) || (cur_tag == tag);
        owner    = '0;
        for (int k = NCACHE - 1; k >= 0; k--) begin
            if (cur_sv[k]) owner = SRC_W'(k);
        end
        others_cnt = '0;
        for (int k = 0; k < NCACHE; k++) begin
            others_cnt = others_cnt + CNT_W'(others[k]);
        end
    end

    // Protocol table: one case per channel and opcode, anything else is bad.
    always_comb begin
        nxt_st    = cur_st;
        nxt_tag   = cur_tag;
        nxt_sv    = cur_sv;
        nxt_cnt   = cur_cnt;
        nxt_psrc  = cur_psrc;
        nxt_ptid  = cur_ptid;
        emit      = 1'b0;
        emit_op   = RS_RSH;
        emit_dst  = src;
        emit_tid  = tid;
        inv_start = 1'b0;
        inv_mask  = '0;
        bad       = 1'b0;
        if (!tag_ok) begin
            bad = 1'b1;
        end else if (!is_ev) begin
            case (op)
                RQ_RD: begin
                    if (cur_st == LN_NONC || cur_st == LN_SHRD) begin
                        nxt_st  = LN_SHRD;
                        nxt_tag = tag;
                        nxt_sv  = (cur_st == LN_NONC) ? src_bit : (cur_sv | src_bit);
                        emit    = 1'b1;
                        emit_op = RS_RSH;
                    end else if (cur_st == LN_EXCL && owner != src) begin
                        nxt_st   = LN_PFWD;
                        nxt_psrc = src;
                        nxt_ptid = tid;
                        emit     = 1'b1;
                        emit_op  = RS_FWD;
                        emit_dst = owner;
                    end else begin
                        bad = 1'b1;
                    end
                end
                RQ_RDX, RQ_UPG: begin
                    if (op == RQ_RDX && cur_st == LN_NONC) begin
                        nxt_st  = LN_EXCL;
                        nxt_tag = tag;
                        nxt_sv  = src_bit;
                        emit    = 1'b1;
                        emit_op = RS_REX;
                    end else if (cur_st == LN_SHRD &&
                                 (op == RQ_RDX || (cur_sv & src_bit) != '0)) begin
                        nxt_sv = src_bit;
                        if (others == '0) begin
                            nxt_st  = LN_EXCL;
                            emit    = 1'b1;
                            emit_op = (op == RQ_UPG) ? RS_GNT : RS_REX;
                        end else begin
                            nxt_st    = LN_PINV;
                            nxt_cnt   = others_cnt;
                            nxt_psrc  = src;
                            nxt_ptid  = tid;
                            inv_start = 1'b1;
                            inv_mask  = others;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
                default: bad = 1'b1;
            endcase
        end else begin
            case (op)
                EV_SUP: begin
                    if (cur_st == LN_PFWD && cur_sv == src_bit) begin
                        nxt_st   = LN_SHRD;
                        nxt_sv   = cur_sv | psrc_bit;
                        emit     = 1'b1;
                        emit_op  = RS_RSH;
                        emit_dst = cur_psrc;
                        emit_tid = cur_ptid;
                    end else begin
                        bad = 1'b1;
                    end
                end
                EV_DROP: begin
                    if (cur_st == LN_SHRD && (cur_sv & src_bit) != '0) begin
                        nxt_sv = others;
                        if (others == '0) nxt_st = LN_NONC;
                    end else if (cur_st == LN_EXCL && cur_sv == src_bit) begin
                        nxt_sv = '0;
                        nxt_st = LN_NONC;
                    end else begin
                        bad = 1'b1;
                    end
                end
                EV_WBK: begin
                    if (cur_st == LN_EXCL && cur_sv == src_bit) begin
                        nxt_sv = '0;
                        nxt_st = LN_NONC;
                    end else begin
                        bad = 1'b1;
                    end
                end
                EV_IACK: begin
                    if (cur_st == LN_PINV && cur_cnt != '0) begin
                        nxt_cnt = cur_cnt - CNT_W'(1);
                        if (cur_cnt == CNT_W'(1)) begin
                            nxt_st   = LN_EXCL;
                            emit     = 1'b1;
                            emit_op  = RS_WCMP;
                            emit_dst = cur_psrc;
                            emit_tid = cur_ptid;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
                default: bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dcl_inv_seq.sv
// Invalidate burst sequencer: holds the target mask, address and id of
// one write and hands out one invalidate per accepted output slot,
// lowest cache id first. Assumes start never arrives while busy.
module dcl_inv_seq #(
    parameter int NCACHE = 4,
    parameter int SRC_W  = 2,
    parameter int ADDR_W = 8,
    parameter int TID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCACHE-1:0] mask_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [TID_W-1:0]  tid_in,
    input  logic              take,
    output logic              busy,
    output logic [SRC_W-1:0]  dst,
    output logic [ADDR_W-1:0] addr,
    output logic [TID_W-1:0]  tid
);
    logic [NCACHE-1:0] mask_q;

    // Pick the lowest remaining target.
    always_comb begin
        busy = |mask_q;
        dst  = '0;
        for (int k = NCACHE - 1; k >= 0; k--) begin
            if (mask_q[k]) dst = SRC_W'(k);
        end
    end

    // Load a new burst or retire the target just sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            addr   <= '0;
            tid    <= '0;
        end else if (start) begin
            mask_q <= mask_in;
            addr   <= addr_in;
            tid    <= tid_in;
        end else if (take) begin
            mask_q <= mask_q & ~(NCACHE'(1) << dst);
        end
    end
endmodule

// File: rtl/dcl_coh_ctrl.sv
// Directory coherence line controller top. Holds NLINES direct-mapped
// directory entries, arbitrates the request and event channels, applies
// one message per cycle through the transition function and drives a
// single registered output slot. Assumes NLINES is a power of two >= 2
// and that line data lives elsewhere.
module dcl_coh_ctrl
    import dcl_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int ADDR_W = 8,
    parameter int TID_W  = 4,
    parameter int NCACHE = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rq_valid,
    output logic                       rq_ready,
    input  logic [2:0]                 rq_op,
    input  logic [ADDR_W-1:0]          rq_addr,
    input  logic [$clog2(NCACHE)-1:0]  rq_src,
    input  logic [TID_W-1:0]           rq_tid,
    input  logic                       ev_valid,
    output logic                       ev_ready,
    input  logic [2:0]                 ev_op,
    input  logic [ADDR_W-1:0]          ev_addr,
    input  logic [$clog2(NCACHE)-1:0]  ev_src,
    output logic                       rs_valid,
    input  logic                       rs_ready,
    output logic [2:0]                 rs_op,
    output logic [ADDR_W-1:0]          rs_addr,
    output logic [$clog2(NCACHE)-1:0]  rs_dst,
    output logic [TID_W-1:0]           rs_tid,
    output logic                       proto_err
);
    localparam int SRC_W = $clog2(NCACHE);
    localparam int CNT_W = $clog2(NCACHE + 1);
    localparam int IDX_W = $clog2(NLINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e          st_a   [NLINES];
    logic [TAG_W-1:0]  tag_a  [NLINES];
    logic [NCACHE-1:0] sv_a   [NLINES];
    logic [CNT_W-1:0]  cnt_a  [NLINES];
    logic [SRC_W-1:0]  psrc_a [NLINES];
    logic [TID_W-1:0]  ptid_a [NLINES];

    logic              sel_ev, fire, rq_blocked, can_take, out_free;
    logic              seq_busy, seq_take;
    logic [SRC_W-1:0]  seq_dst;
    logic [ADDR_W-1:0] seq_addr;
    logic [TID_W-1:0]  seq_tid;
    logic [IDX_W-1:0]  rq_idx, m_idx;
    logic [ADDR_W-1:0] m_addr;
    logic [2:0]        m_op;
    logic [SRC_W-1:0]  m_src;
    logic [TID_W-1:0]  m_tid;

    line_st_e          nxt_st;
    logic [TAG_W-1:0]  nxt_tag;
    logic [NCACHE-1:0] nxt_sv, inv_mask;
    logic [CNT_W-1:0]  nxt_cnt;
    logic [SRC_W-1:0]  nxt_psrc, emit_dst;
    logic [TID_W-1:0]  nxt_ptid, emit_tid;
    logic              emit, inv_start, bad;
    logic [2:0]        emit_op;

    // Message selection and line lookup.
    always_comb begin
        out_free   = !rs_valid || rs_ready;
        can_take   = !seq_busy && out_free;
        seq_take   = seq_busy && out_free;
        rq_idx     = rq_addr[IDX_W-1:0];
        rq_blocked = (st_a[rq_idx] == LN_PFWD) || (st_a[rq_idx] == LN_PINV);
        m_addr     = sel_ev ? ev_addr : rq_addr;
        m_op       = sel_ev ? ev_op   : rq_op;
        m_src      = sel_ev ? ev_src  : rq_src;
        m_tid      = sel_ev ? '0      : rq_tid;
        m_idx      = m_addr[IDX_W-1:0];
    end

    dcl_in_arb u_arb (
        .rq_valid   (rq_valid),
        .ev_valid   (ev_valid),
        .rq_blocked (rq_blocked),
        .can_take   (can_take),
        .rq_ready   (rq_ready),
        .ev_ready   (ev_ready),
        .sel_ev     (sel_ev),
        .fire       (fire)
    );

    dcl_xition #(
        .NCACHE (NCACHE), .SRC_W (SRC_W), .CNT_W (CNT_W),
        .TAG_W  (TAG_W),  .TID_W (TID_W)
    ) u_xition (
        .is_ev     (sel_ev),
        .op        (m_op),
        .tag       (m_addr[ADDR_W-1:IDX_W]),
        .src       (m_src),
        .tid       (m_tid),
        .cur_st    (st_a[m_idx]),
        .cur_tag   (tag_a[m_idx]),
        .cur_sv    (sv_a[m_idx]),
        .cur_cnt   (cnt_a[m_idx]),
        .cur_psrc  (psrc_a[m_idx]),
        .cur_ptid  (ptid_a[m_idx]),
        .nxt_st    (nxt_st),
        .nxt_tag   (nxt_tag),
        .nxt_sv    (nxt_sv),
        .nxt_cnt   (nxt_cnt),
        .nxt_psrc  (nxt_psrc),
        .nxt_ptid  (nxt_ptid),
        .emit      (emit),
        .emit_op   (emit_op),
        .emit_dst  (emit_dst),
        .emit_tid  (emit_tid),
        .inv_start (inv_start),
        .inv_mask  (inv_mask),
        .bad       (bad)
    );

    dcl_inv_seq #(
        .NCACHE (NCACHE), .SRC_W (SRC_W), .ADDR_W (ADDR_W), .TID_W (TID_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fire && inv_start),
        .mask_in (inv_mask),
        .addr_in (m_addr),
        .tid_in  (m_tid),
        .take    (seq_take),
        .busy    (seq_busy),
        .dst     (seq_dst),
        .addr    (seq_addr),
        .tid     (seq_tid)
    );

    // One register set per tracked line.
    for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
        line_st_e          st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [NCACHE-1:0] sv_q;
        logic [CNT_W-1:0]  cnt_q;
        logic [SRC_W-1:0]  psrc_q;
        logic [TID_W-1:0]  ptid_q;
        logic              hit;

        assign hit = fire && (m_idx == IDX_W'(gi));

        // Entry update when the selected message targets this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= LN_NONC;
                tag_q  <= '0;
                sv_q   <= '0;
                cnt_q  <= '0;
                psrc_q <= '0;
                ptid_q <= '0;
            end else if (hit) begin
                st_q   <= nxt_st;
                tag_q  <= nxt_tag;
                sv_q   <= nxt_sv;
                cnt_q  <= nxt_cnt;
                psrc_q <= nxt_psrc;
                ptid_q <= nxt_ptid;
            end
        end

        assign st_a[gi]   = st_q;
        assign tag_a[gi]  = tag_q;
        assign sv_a[gi]   = sv_q;
        assign cnt_a[gi]  = cnt_q;
        assign psrc_a[gi] = psrc_q;
        assign ptid_a[gi] = ptid_q;
    end

    // Output slot: invalidate burst first, then transition output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_op    <= RS_RSH;
            rs_addr  <= '0;
            rs_dst   <= '0;
            rs_tid   <= '0;
        end else if (seq_take) begin
            rs_valid <= 1'b1;
            rs_op    <= RS_INV;
            rs_addr  <= seq_addr;
            rs_dst   <= seq_dst;
            rs_tid   <= seq_tid;
        end else if (fire && emit) begin
            rs_valid <= 1'b1;
            rs_op    <= emit_op;
            rs_addr  <= m_addr;
            rs_dst   <= emit_dst;
            rs_tid   <= emit_tid;
        end else if (rs_ready) begin
            rs_valid <= 1'b0;
        end
    end

    // Sticky unexpected-message flag.
    always_ff @(posedge clk) begin
        if (!rst_n)          proto_err <= 1'b0;
        else if (fire && bad) proto_err <= 1'b1;
    end
endmodule

// File: rtl/dcl_coh_ctrl_chk.sv
// Port-level checker for dcl_coh_ctrl, attached with bind below.
module dcl_coh_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int TID_W  = 4,
    parameter int SRC_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rq_valid,
    input logic              rq_ready,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              rs_valid,
    input logic              rs_ready,
    input logic [2:0]        rs_op,
    input logic [ADDR_W-1:0] rs_addr,
    input logic [SRC_W-1:0]  rs_dst,
    input logic [TID_W-1:0]  rs_tid,
    input logic              proto_err
);
    // R1: reset clears the output slot and the error flag.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rs_valid && !proto_err));

    // R8: no request accepted while an event is offered.
    assert_event_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> !rq_ready);

    // R9: the error flag never clears on its own.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R9: the error flag only rises right after an accepted message.
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past((rq_valid && rq_ready) || (ev_valid && ev_ready)));

    // R10: a stalled outgoing message holds every field.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_op) && $stable(rs_addr)
                                     && $stable(rs_dst) && $stable(rs_tid)));

    // R10: only defined outgoing opcodes appear.
    assert_legal_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_op <= 3'd5));
endmodule

bind dcl_coh_ctrl dcl_coh_ctrl_chk #(
    .ADDR_W (ADDR_W), .TID_W (TID_W), .SRC_W ($clog2(NCACHE))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_valid  (rq_valid),
    .rq_ready  (rq_ready),
    .ev_valid  (ev_valid),
    .ev_ready  (ev_ready),
    .rs_valid  (rs_valid),
    .rs_ready  (rs_ready),
    .rs_op     (rs_op),
    .rs_addr   (rs_addr),
    .rs_dst    (rs_dst),
    .rs_tid    (rs_tid),
    .proto_err (proto_err)
);

// File: tb/dcl_coh_ctrl_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue expected outgoing messages, a
// monitor pops and compares them on every output handshake.
module dcl_coh_ctrl_tb;
    typedef struct packed {
        logic [2:0] op;
        logic [7:0] addr;
        logic [1:0] dst;
        logic [3:0] tid;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rq_valid = 1'b0, ev_valid = 1'b0, rs_ready = 1'b1;
    logic [2:0] rq_op = '0, ev_op = '0;
    logic [7:0] rq_addr = '0, ev_addr = '0;
    logic [1:0] rq_src = '0, ev_src = '0;
    logic [3:0] rq_tid = '0;
    logic       rq_ready, ev_ready, rs_valid, proto_err;
    logic [2:0] rs_op;
    logic [7:0] rs_addr;
    logic [1:0] rs_dst;
    logic [3:0] rs_tid;

    int    n_checks = 0;
    int    n_errors = 0;
    item_t exp_q[$];
    string req_q[$];

    always #2 clk = ~clk;

    dcl_coh_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .rq_valid (rq_valid), .rq_ready (rq_ready), .rq_op (rq_op),
        .rq_addr (rq_addr), .rq_src (rq_src), .rq_tid (rq_tid),
        .ev_valid (ev_valid), .ev_ready (ev_ready), .ev_op (ev_op),
        .ev_addr (ev_addr), .ev_src (ev_src),
        .rs_valid (rs_valid), .rs_ready (rs_ready), .rs_op (rs_op),
        .rs_addr (rs_addr), .rs_dst (rs_dst), .rs_tid (rs_tid),
        .proto_err (proto_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic expect_out(input logic [2:0] op, input logic [7:0] a,
                              input logic [1:0] d, input logic [3:0] t, input string req);
        exp_q.push_back('{op: op, addr: a, dst: d, tid: t});
        req_q.push_back(req);
    endtask

    task automatic send_rq(input logic [2:0] op, input logic [7:0] a,
                           input logic [1:0] s, input logic [3:0] t);
        @(negedge clk);
        rq_valid = 1'b1; rq_op = op; rq_addr = a; rq_src = s; rq_tid = t;
        #0.3;
        while (!rq_ready) begin
            @(negedge clk);
            #0.3;
        end
        @(posedge clk);
        #0.3 rq_valid = 1'b0;
    endtask

    task automatic send_ev(input logic [2:0] op, input logic [7:0] a, input logic [1:0] s);
        @(negedge clk);
        ev_valid = 1'b1; ev_op = op; ev_addr = a; ev_src = s;
        #0.3;
        while (!ev_ready) begin
            @(negedge clk);
            #0.3;
        end
        @(posedge clk);
        #0.3 ev_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "drain", exp_q.size(), 0);
    endtask

    // Monitor: compare each output handshake with the queue head.
    always begin : monitor
        item_t got, want;
        string req;
        @(negedge clk);
        #0.6;
        if (rst_n && rs_valid && rs_ready) begin
            got = '{op: rs_op, addr: rs_addr, dst: rs_dst, tid: rs_tid};
            if (exp_q.size() == 0) begin
                check(1'b0, "unsolicited output (R7/R9)", int'(got), 0);
            end else begin
                want = exp_q.pop_front();
                req  = req_q.pop_front();
                check(got == want, req, int'(got), int'(want));
            end
        end
    end

    localparam logic [7:0] LA = 8'h10, LB = 8'h21, LC = 8'h32, LD = 8'h13, LX = 8'h20;

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.3 rst_n = 1'b1;
        @(negedge clk); #0.3;
        check(!rs_valid, "R1 rs_valid after reset", rs_valid, 0);
        check(!proto_err, "R1 proto_err after reset", proto_err, 0);
        check(rq_ready, "R1 rq_ready idle", rq_ready, 1);

        // R2: exclusive fill, R3: second reader forwards to owner 0.
        expect_out(3'd1, LA, 2'd0, 4'h1, "R2 exclusive response");
        send_rq(3'd1, LA, 2'd0, 4'h1);
        drain();
        expect_out(3'd2, LA, 2'd0, 4'h2, "R3 forward to owner");
        send_rq(3'd0, LA, 2'd1, 4'h2);
        drain();
        @(negedge clk);
        rq_valid = 1'b1; rq_op = 3'd0; rq_addr = LA; rq_src = 2'd2; rq_tid = 4'h9;
        #0.3 check(!rq_ready, "R3 request held while forward pending", rq_ready, 0);
        repeat (2) @(negedge clk);
        #0.3 check(!rq_ready, "R3 request still held", rq_ready, 0);
        rq_valid = 1'b0;

        // R4: owner supplies, reader gets the saved tid.
        expect_out(3'd0, LA, 2'd1, 4'h2, "R4 shared response to reader");
        send_ev(3'd0, LA, 2'd0);
        drain();
        expect_out(3'd0, LA, 2'd2, 4'h3, "R2 third sharer added");
        send_rq(3'd0, LA, 2'd2, 4'h3);
        drain();

        // R7: upgrade from cache 1 against sharers 0 and 2.
        expect_out(3'd4, LA, 2'd0, 4'h4, "R7 invalidate cache 0");
        expect_out(3'd4, LA, 2'd2, 4'h4, "R7 invalidate cache 2");
        send_rq(3'd2, LA, 2'd1, 4'h4);
        drain();
        send_ev(3'd3, LA, 2'd0);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R7 no early write complete", exp_q.size(), 0);
        expect_out(3'd5, LA, 2'd1, 4'h4, "R7 write complete after last ack");
        send_ev(3'd3, LA, 2'd2);
        drain();

        // R6: writeback, new reader, drop, then a clean exclusive fill.
        send_ev(3'd2, LA, 2'd1);
        expect_out(3'd0, LA, 2'd3, 4'h5, "R2 read on Noncached line");
        send_rq(3'd0, LA, 2'd3, 4'h5);
        drain();
        send_ev(3'd1, LA, 2'd3);
        expect_out(3'd1, LA, 2'd2, 4'h6, "R6 line back to Noncached");
        send_rq(3'd1, LA, 2'd2, 4'h6);
        drain();

        // R5: sole sharer upgrade.
        expect_out(3'd0, LB, 2'd0, 4'h7, "R2 read line B");
        send_rq(3'd0, LB, 2'd0, 4'h7);
        expect_out(3'd3, LB, 2'd0, 4'h8, "R5 grant to sole sharer");
        send_rq(3'd2, LB, 2'd0, 4'h8);
        drain();

        // R8: event and request offered together.
        expect_out(3'd0, LC, 2'd1, 4'h9, "R2 read line C");
        send_rq(3'd0, LC, 2'd1, 4'h9);
        drain();
        expect_out(3'd0, LD, 2'd2, 4'hA, "R8 request served after event");
        @(negedge clk);
        rq_valid = 1'b1; rq_op = 3'd0; rq_addr = LD; rq_src = 2'd2; rq_tid = 4'hA;
        ev_valid = 1'b1; ev_op = 3'd1; ev_addr = LC; ev_src = 2'd1;
        #0.3;
        check(ev_ready, "R8 event accepted", ev_ready, 1);
        check(!rq_ready, "R8 request waits", rq_ready, 0);
        @(posedge clk);
        #0.3 ev_valid = 1'b0;
        @(negedge clk); #0.3;
        check(rq_ready, "R8 request accepted next", rq_ready, 1);
        @(posedge clk);
        #0.3 rq_valid = 1'b0;
        drain();

        // R10: output stalls and holds.
        rs_ready = 1'b0;
        expect_out(3'd0, LD, 2'd3, 4'hB, "R10 held response delivered");
        send_rq(3'd0, LD, 2'd3, 4'hB);
        repeat (3) @(negedge clk);
        #0.3;
        check(rs_valid, "R10 valid held", rs_valid, 1);
        check(rs_dst == 2'd3 && rs_tid == 4'hB, "R10 fields held", {rs_dst, rs_tid}, {2'd3, 4'hB});
        rs_ready = 1'b1;
        drain();

        // R9: tag conflict, then an acknowledgement with no pending write.
        check(!proto_err, "R9 no error before bad message", proto_err, 0);
        send_rq(3'd0, LX, 2'd1, 4'hC);
        repeat (2) @(negedge clk);
        check(proto_err, "R9 error on tag conflict", proto_err, 1);
        send_ev(3'd3, LB, 2'd0);
        repeat (4) @(negedge clk);
        check(proto_err, "R9 error stays set", proto_err, 1);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule